// File: doc/BRIEF.md
# TDM Time Slot Assigner

This block routes one serial TDM line to a set of internal serial channel controllers. A host loads a routing table made of variable-length entries. On each frame sync the block walks the table one entry at a time, for both the receive and the transmit direction.

Each entry names a destination and a span, counted in bits or in bytes. Receive bits are handed to the selected channel with a one-clock strobe. On transmit, the selected channel's bit is put on the line.

Two entry codes do not route data. One skips the span. The other fires a sampling strobe that delivers a single line bit, such as an access-grant bit, to a dedicated controller.

The serial clock is sampled in the system clock domain. Its rising edge marks receive sampling and its falling edge marks transmit launch. The host may reprogram the table only while the block is disabled.

Top module: `tsa_router`

## Requirements
- R1: A table word is 16 bits: bit 15 is the last-entry flag, bit 14 the byte-unit flag, bits 13:10 the count, bits 9:7 the channel select, and bits 6:0 are kept but have no effect.
- R2: On a rising serial clock edge that falls in an entry with select 1 to 6, `rx_stb[select-1]` pulses for the one clock following the edge, and `rx_bit` then holds the line bit sampled at that edge.
- R3: During an entry with select 0, no receive strobe, no grant strobe and no transmit request is raised, and the line output is idle.
- R4: During an entry with select 7, `grant_stb` pulses on each rising edge of the span with `grant_bit` equal to the sampled line bit, and no channel strobe is raised.
- R5: After the span of the entry with the last flag set, no routing happens until the next frame sync, which restarts the walk at entry 0.
- R6: The transmit table starts at word DEPTH (128 by default). Its first bit is launched on the first falling edge after the rising edge that sampled the frame sync. On each routed falling edge, `tx_req[select-1]` pulses and `txd` holds `tx_data[select-1]` with `txen` high until the next falling edge.
- R7: Outside a routed transmit slot, and while disabled, `txen` is low and `txd` is high.
- R8: A frame sync that arrives while an entry span is still running raises `frame_err` for exactly one clock, and that bit is counted as bit 0 of entry 0.
- R9: Table writes are ignored while `en` is high. After `en` rises, nothing is routed until a frame sync is sampled.
- R10: An entry spans count+1 bits when the unit flag is 0, and 8*(count+1) bits when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables table walking; table writes require it low |
| sclk | input | 1 | Serial bit clock, synchronous to clk, high and low for at least one clk each |
| fsync | input | 1 | Frame sync, sampled on the rising sclk edge |
| rxd | input | 1 | Line receive data |
| rx_stb | output | 6 | Per-channel receive bit strobe |
| rx_bit | output | 1 | Receive bit belonging to the current strobe |
| grant_stb | output | 1 | Strobe for a bit sampled under select 7 |
| grant_bit | output | 1 | Sampled grant bit |
| tx_data | input | 6 | Next transmit bit offered by each channel |
| tx_req | output | 6 | Per-channel transmit bit taken |
| txd | output | 1 | Line transmit data |
| txen | output | 1 | Line driver enable; low means high impedance |
| frame_err | output | 1 | One-clock pulse on an early frame sync |
| wr_en | input | 1 | Host table write strobe |
| wr_addr | input | 8 | Table word address; upper half is the transmit section |
| wr_data | input | 16 | Table word |

## Verification
The hardest cases to reach are a frame sync that lands in the middle of an entry span, and the bits that follow a frame's last entry before the next sync arrives. Both depend on where the table walk stands in time.

The bench keeps its own bit position against a map of the table that it expands itself. It drives frames longer than the table span, so trailing idle bits occur. It also injects a sync partway through a frame.

A sweep programs a two-entry table for every select code, both unit flags and several counts. This covers entry-boundary and wrap behaviour, with different codes in the receive and transmit sections.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int CSEL_W = 3;
  localparam int CNT_W  = 4;
  localparam int NCH    = (1 << CSEL_W) - 2;
  localparam int SPAN_W = CNT_W + 3;
  localparam int WORD_W = 16;

  localparam logic [CSEL_W-1:0] CSEL_SKIP   = '0;
  localparam logic [CSEL_W-1:0] CSEL_STROBE = '1;

  typedef struct packed {
    logic              last;
    logic              byte_unit;
    logic [CNT_W-1:0]  cnt;
    logic [CSEL_W-1:0] csel;
    logic [6:0]        aux;
  } tsa_entry_t;

  // span length minus one, in bits
  function automatic logic [SPAN_W-1:0] span_m1(tsa_entry_t e);
    return e.byte_unit ? {e.cnt, 3'b111} : {3'b000, e.cnt};
  endfunction

  function automatic logic [NCH-1:0] chan_onehot(logic [CSEL_W-1:0] sel);
    logic [NCH-1:0] oh;
    for (int i = 0; i < NCH; i++) oh[i] = (sel == CSEL_W'(i + 1));
    return oh;
  endfunction
endpackage

// File: rtl/tsa_table.sv
module tsa_table
  import tsa_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int AW    = IDX_W + 1
) (
  input  logic             clk,
  input  logic             wr_ok,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx_rx,
  input  logic [IDX_W-1:0] rd_idx_tx,
  output tsa_entry_t       ent_rx,
  output tsa_entry_t       ent_tx
);
  logic [WORD_W-1:0] mem [2*DEPTH];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= wr_data;
  end

  assign ent_rx = tsa_entry_t'(mem[{1'b0, rd_idx_rx}]);
  assign ent_tx = tsa_entry_t'(mem[{1'b1, rd_idx_tx}]);
endmodule

// File: rtl/tsa_edge.sv
module tsa_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sclk,
  input  logic fsync,
  output logic rise,
  output logic fall,
  output logic start_rx,
  output logic start_tx
);
  logic sclk_q, armed_q, armed_d;

  assign rise     = sclk & ~sclk_q;
  assign fall     = ~sclk & sclk_q;
  assign start_rx = rise & fsync;
  assign start_tx = fall & armed_q;

  always_comb begin
    armed_d = armed_q;
    if (!en)                armed_d = 1'b0;
    else if (rise && fsync) armed_d = 1'b1;
    else if (fall)          armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/tsa_seq.sv
module tsa_seq
  import tsa_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              step,
  input  logic              start,
  input  tsa_entry_t        entry,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              hit,
  output logic [CSEL_W-1:0] hit_sel,
  output logic              overrun
);
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [SPAN_W-1:0] rem_q, rem_d, rem_cur;
  logic              fresh_q, fresh_d, act_q, act_d;
  logic              go, fresh;

  assign go      = en & step & (start | act_q);
  assign rd_idx  = start ? '0 : idx_q;
  assign fresh   = start | fresh_q;
  assign rem_cur = fresh ? span_m1(entry) : rem_q;
  assign hit     = go;
  assign hit_sel = entry.csel;
  assign overrun = en & step & start & act_q;

  always_comb begin
    idx_d   = idx_q;
    rem_d   = rem_q;
    fresh_d = fresh_q;
    act_d   = act_q;
    if (!en) begin
      idx_d   = '0;
      rem_d   = '0;
      fresh_d = 1'b1;
      act_d   = 1'b0;
    end else if (go) begin
      if (rem_cur == '0) begin
        fresh_d = 1'b1;
        rem_d   = '0;
        if (entry.last) begin
          idx_d = '0;
          act_d = 1'b0;
        end else begin
          idx_d = rd_idx + 1'b1;
          act_d = 1'b1;
        end
      end else begin
        rem_d   = rem_cur - 1'b1;
        fresh_d = 1'b0;
        idx_d   = rd_idx;
        act_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      rem_q   <= '0;
      fresh_q <= 1'b1;
      act_q   <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      rem_q   <= rem_d;
      fresh_q <= fresh_d;
      act_q   <= act_d;
    end
  end
endmodule

// File: rtl/tsa_router.sv
module tsa_router
  import tsa_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int AW    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sclk,
  input  logic              fsync,
  input  logic              rxd,
  output logic [NCH-1:0]    rx_stb,
  output logic              rx_bit,
  output logic              grant_stb,
  output logic              grant_bit,
  input  logic [NCH-1:0]    tx_data,
  output logic [NCH-1:0]    tx_req,
  output logic              txd,
  output logic              txen,
  output logic              frame_err,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data
);
  logic rise, fall, start_rx, start_tx;
  logic [1:0] step_v, start_v, hit_v, ovr_v;
  logic [IDX_W-1:0]  idx_v [2];
  logic [CSEL_W-1:0] sel_v [2];
  tsa_entry_t        ent_v [2];

  tsa_edge u_edge (
    .clk(clk), .rst_n(rst_n), .en(en), .sclk(sclk), .fsync(fsync),
    .rise(rise), .fall(fall), .start_rx(start_rx), .start_tx(start_tx)
  );

  tsa_table #(.DEPTH(DEPTH)) u_table (
    .clk(clk), .wr_ok(wr_en & ~en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_idx_rx(idx_v[0]), .rd_idx_tx(idx_v[1]),
    .ent_rx(ent_v[0]), .ent_tx(ent_v[1])
  );

  assign step_v  = {fall, rise};
  assign start_v = {start_tx, start_rx};

  // index 0 walks the receive section, index 1 the transmit section
  for (genvar d = 0; d < 2; d++) begin : g_dir
    tsa_seq #(.IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en),
      .step(step_v[d]), .start(start_v[d]), .entry(ent_v[d]),
      .rd_idx(idx_v[d]), .hit(hit_v[d]), .hit_sel(sel_v[d]),
      .overrun(ovr_v[d])
    );
  end

  logic [NCH-1:0] rx_stb_d, tx_req_d, tx_oh;
  logic rx_bit_d, grant_stb_d, grant_bit_d, txd_d, txen_d, err_d;

  assign tx_oh = hit_v[1] ? chan_onehot(sel_v[1]) : '0;

  always_comb begin
    rx_stb_d    = hit_v[0] ? chan_onehot(sel_v[0]) : '0;
    grant_stb_d = hit_v[0] && (sel_v[0] == CSEL_STROBE);
    rx_bit_d    = hit_v[0] ? rxd : rx_bit;
    grant_bit_d = grant_stb_d ? rxd : grant_bit;
    err_d       = ovr_v[0];
    tx_req_d    = (en && fall) ? tx_oh : '0;
    txen_d      = txen;
    txd_d       = txd;
    if (!en) begin
      txen_d = 1'b0;
      txd_d  = 1'b1;
    end else if (fall) begin
      txen_d = |tx_oh;
      txd_d  = (|tx_oh) ? |(tx_oh & tx_data) : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_stb    <= '0;
      rx_bit    <= 1'b0;
      grant_stb <= 1'b0;
      grant_bit <= 1'b0;
      frame_err <= 1'b0;
      tx_req    <= '0;
      txen      <= 1'b0;
      txd       <= 1'b1;
    end else begin
      rx_stb    <= rx_stb_d;
      rx_bit    <= rx_bit_d;
      grant_stb <= grant_stb_d;
      grant_bit <= grant_bit_d;
      frame_err <= err_d;
      tx_req    <= tx_req_d;
      txen      <= txen_d;
      txd       <= txd_d;
    end
  end
endmodule

// File: rtl/tsa_router_chk.sv
module tsa_router_chk
  import tsa_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic [NCH-1:0] rx_stb,
  input logic           grant_stb,
  input logic [NCH-1:0] tx_req,
  input logic           txd,
  input logic           txen,
  input logic           frame_err
);
  // R2
  rx_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_stb));
  // R2
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb != '0) |=> (rx_stb == '0));
  // R4
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_stb |-> (rx_stb == '0));
  // R6
  tx_req_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req != '0) |-> (txen && $onehot0(tx_req)));
  // R7
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txen |-> txd);
  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!txen && rx_stb == '0 && !grant_stb && !frame_err));
endmodule

bind tsa_router tsa_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .rx_stb(rx_stb), .grant_stb(grant_stb),
  .tx_req(tx_req), .txd(txd), .txen(txen), .frame_err(frame_err)
);

// File: tb/tsa_router_tb.sv
module tsa_router_tb;
  import tsa_pkg::*;

  logic clk, rst_n, en, sclk, fsync, rxd, wr_en;
  logic [NCH-1:0] rx_stb, tx_data, tx_req;
  logic rx_bit, grant_stb, grant_bit, txd, txen, frame_err;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;

  int n_chk = 0, n_fail = 0;
  logic [15:0] sh [256];
  int map [2][1024];
  int flen [2];
  int pos;
  bit started;
  bit done = 0;

  tsa_router u_dut (.*);

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (bit %0d)", tag, act, exp, pos);
    end
  endtask

  // R1 field layout
  function automatic logic [15:0] enc(bit last, bit unit, int cnt, int csel);
    return {last, unit, 4'(cnt), 3'(csel), 7'b0};
  endfunction

  task automatic wr(int a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 8'(a); wr_data = d;
    if (!en) sh[a] = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // R10 span = (cnt+1) bits or bytes
  task automatic build(int w);
    int p = 0;
    for (int i = 0; i < 128; i++) begin
      logic [15:0] e = sh[w*128 + i];
      int len = (int'(e[13:10]) + 1) * (e[14] ? 8 : 1);
      for (int k = 0; k < len; k++) begin
        map[w][p] = int'(e[9:7]);
        p++;
      end
      if (e[15]) break;
    end
    flen[w] = p;
  endtask

  task automatic do_bit(bit fs);
    logic d;
    logic [NCH-1:0] td, es, er, ea;
    int srx, stx;
    bit eerr, eg, et;
    string tg;
    d  = 1'($urandom);
    td = NCH'($urandom);
    eerr = 0;
    if (en && fs) begin
      eerr = started && (pos < flen[0]);
      pos = 0;
      started = 1;
    end
    srx = (en && started && pos < flen[0]) ? map[0][pos] : -1;
    stx = (en && started && pos < flen[1]) ? map[1][pos] : -1;
    @(negedge clk);
    sclk = 1; fsync = fs; rxd = d; tx_data = td;
    @(negedge clk);
    es = (srx >= 1 && srx <= 6) ? NCH'(1 << (srx - 1)) : '0;
    eg = (srx == 7);
    tg = (srx < 0) ? "R5" : (srx == 0) ? "R3" : (srx == 7) ? "R4" : "R2";
    chk({rx_stb, grant_stb} == {es, eg} &&
        (es == '0 || rx_bit == d) && (!eg || grant_bit == d), tg,
        {rx_stb, grant_stb, rx_bit, grant_bit}, {es, eg, d, d});
    chk(frame_err == eerr, "R8", 32'(frame_err), 32'(eerr));
    fsync = 0;
    @(negedge clk);
    sclk = 0;
    @(negedge clk);
    er = (stx >= 1 && stx <= 6) ? NCH'(1 << (stx - 1)) : '0;
    et = (er != '0);
    ea = td & er;
    tg = et ? "R6" : "R7";
    chk(tx_req == er && txen == et && txd == (et ? |ea : 1'b1), tg,
        {tx_req, txen, txd}, {er, et, (et ? |ea : 1'b1)});
    if (started) pos++;
  endtask

  task automatic set_en(bit v);
    @(negedge clk);
    en = v;
    if (!v) started = 0;
  endtask

  initial begin
    int cv [4] = '{0, 1, 7, 15};
    rst_n = 0; en = 0; sclk = 0; fsync = 0; rxd = 0; wr_en = 0;
    wr_addr = 0; wr_data = 0; tx_data = 0; started = 0; pos = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rx_stb == 0 && !txen && txd && !frame_err && !grant_stb, "R7",
        {rx_stb, txen, txd, frame_err}, {6'b0, 1'b0, 1'b1, 1'b0});

    for (int a = 0; a < 256; a++) wr(a, 16'h8000);
    // typical frame, same in both sections
    for (int s = 0; s < 2; s++) begin
      wr(s*128 + 0, enc(0, 1, 0, 2));
      wr(s*128 + 1, enc(0, 1, 0, 4));
      wr(s*128 + 2, enc(0, 1, 0, 5));
      wr(s*128 + 3, enc(0, 0, 1, 1));
      wr(s*128 + 4, enc(0, 0, 5, 2));
      wr(s*128 + 5, enc(0, 1, 6, 0));
      wr(s*128 + 6, enc(0, 0, 1, 0));
      wr(s*128 + 7, enc(1, 0, 0, 7));
    end
    build(0); build(1);

    // R9 disabled: sync ignored; then enabled without sync: nothing
    for (int i = 0; i < 3; i++) do_bit(1);
    set_en(1);
    for (int i = 0; i < 4; i++) do_bit(0);
    for (int f = 0; f < 3; f++) begin
      do_bit(1);
      for (int i = 1; i < 95; i++) do_bit(0);
    end

    // R8 early sync at bit 20
    do_bit(1);
    for (int i = 1; i < 20; i++) do_bit(0);
    do_bit(1);
    for (int i = 1; i < 93; i++) do_bit(0);

    // R9 write while enabled has no effect
    wr(0, enc(1, 0, 3, 6));
    wr(128, enc(1, 0, 3, 6));
    do_bit(1);
    for (int i = 1; i < 94; i++) do_bit(0);

    // R1 R10 sweep: select x unit x count, tx section differs (R6)
    for (int c = 0; c < 8; c++)
      for (int u = 0; u < 2; u++)
        for (int k = 0; k < 4; k++) begin
          set_en(0);
          wr(0,   enc(0, u, cv[k], c));
          wr(1,   enc(1, 0, 1, (c + 1) % 8));
          wr(128, enc(0, u, cv[k], 7 - c));
          wr(129, enc(1, 0, 1, (c + 3) % 8));
          build(0); build(1);
          set_en(1);
          do_bit(1);
          for (int i = 1; i < flen[0] + 3; i++) do_bit(0);
        end

    set_en(0);
    do_bit(1);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule